// File: doc/BRIEF.md
# Host Register Port with Selectable Access Timing

This block sits between a host processor's byte-wide local bus and a bank of 64 one-byte registers. The host starts an access by pulling chip select low. It supplies a 6-bit address and a direction pin, and it sees completion through a ready output. The data bus is split into an input byte, an output byte and a shared output enable, so the pad ring can form the tristate bus. Only the lowest byte of a wider host bus is ever driven. Ready also has its own output enable.

Two static mode pins choose the bus personality. With `acc_mode[1]`=0 every access lasts exactly five clocks and ready is tristated between accesses, which suits processors that expect a fixed-length cycle. With `acc_mode[1]`=1 the access lasts as long as chip select stays low, but at least five clocks. In that mode ready is always driven, and raising chip select releases the bus at once. `acc_mode[0]` sets the direction-pin polarity.

The sequencer has eight named states:
- IDLE waits for chip select.
- PH1 to PH4 are the first four clocks of an access.
- PH5 is the fifth clock, when ready goes low, read data is driven and a write is committed.
- HOLD extends PH5 while chip select stays low in the variable mode.
- REC is one recovery clock after chip select rises.

The transitions are:
- IDLE to PH1 on chip select sampled low.
- PHn to PHn+1 on every clock.
- PH5 to PH1 for a back-to-back access in the fixed mode, and PH5 to IDLE otherwise in that mode.
- PH5 to HOLD, and HOLD to HOLD, while chip select stays low in the variable mode.
- PH1 to PH5 and HOLD go to REC when chip select is sampled high in the variable mode.
- REC to IDLE always.

Top module: `hrp_port`

## Requirements
- R1: After reset every register reads 0x00, `data_oe` is 0 and, with `acc_mode[1]`=0, `rdy_oe` is 0.
- R2: With `acc_mode[1]`=0, an access starts at the first rising edge that samples `cs_n` low in IDLE. The five clocks after that edge drive `rdy_oe`=1, with `rdy_out`=1 in clocks 1 to 4 and `rdy_out`=0 in clock 5. `rdy_oe` is 0 in every other clock. The level of `cs_n` during clocks 1 to 4 has no effect.
- R3: With `acc_mode[1]`=0, a read drives `data_oe`=1 with the addressed register on `data_out` in clock 5 only.
- R4: `acc_mode[0]`=1 makes `dir`=0 a write and `dir`=1 a read. `acc_mode[0]`=0 makes `dir`=1 a write and `dir`=0 a read. Address and direction are captured at the edge that starts the access.
- R5: With `acc_mode[1]`=0, `cs_n` sampled low at the edge that ends clock 5 starts the next access directly, with no idle clock between the two accesses.
- R6: With `acc_mode[1]`=1, `rdy_oe` is always 1. `rdy_out` is 0 and a read drives `data_out` with `data_oe`=1 from clock 5 for as long as `cs_n` stays low.
- R7: With `acc_mode[1]`=1, `cs_n`=1 forces `rdy_out`=1 and `data_oe`=0 in the same clock, before any clock edge.
- R8: With `acc_mode[1]`=1, the clock after `cs_n` is sampled high is a recovery clock in which `cs_n` low is not sampled.
- R9: With `acc_mode[1]`=1, `cs_n` sampled high in clocks 1 to 4 abandons the access, and no register is written.
- R10: A write stores `data_in` as sampled at the edge ending clock 5, exactly once per access, even when `cs_n` is held low longer.
- R11: All 64 addresses, 0 through 63, hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_mode | input | 2 | [1]: 0 fixed five-clock, 1 chip-select length; [0]: 1 direction low writes, 0 direction high writes |
| addr | input | 6 | Register address |
| cs_n | input | 1 | Active-low chip select |
| dir | input | 1 | Direction pin, polarity set by acc_mode[0] |
| data_in | input | 8 | Write byte from the host bus |
| data_out | output | 8 | Read byte toward the host bus |
| data_oe | output | 1 | Enable for the data bus drivers |
| rdy_out | output | 1 | Ready level, low means the access completes |
| rdy_oe | output | 1 | Enable for the ready driver |

## Verification
The checker watches the port-level timing rules on every clock:
- the single-clock ready-low pulse, preceded by four driven high clocks, in the fixed mode;
- ready always driven in the variable mode;
- data never driven unless ready is driven low;
- the immediate release when chip select rises;
- the single write strobe per access.

Whether the right byte was stored or returned can only be shown by the bench's scenarios. The same holds for the polarity of the direction pin, the back-to-back chaining, the ignored recovery clock and the abandoned access.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PH1,
        ST_PH2,
        ST_PH3,
        ST_PH4,
        ST_PH5,
        ST_HOLD,
        ST_REC
    } hrp_state_e;
endpackage

// File: rtl/hrp_seq.sv
module hrp_seq
    import hrp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_var,
    input  logic              wr_low,
    input  logic              cs_n,
    input  logic              dir,
    input  logic [ADDR_W-1:0] addr,
    output hrp_state_e        state,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              commit
);
    hrp_state_e state_d;
    logic       start;

    // next-state logic
    always_comb begin
        state_d = state;
        start   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!cs_n) begin
                    state_d = ST_PH1;
                    start   = 1'b1;
                end
            end
            ST_PH1, ST_PH2, ST_PH3, ST_PH4: begin
                if (len_var && cs_n) state_d = ST_REC;
                else                 state_d = hrp_state_e'(state + 3'd1);
            end
            ST_PH5: begin
                if (len_var) begin
                    state_d = cs_n ? ST_REC : ST_HOLD;
                end else if (!cs_n) begin
                    state_d = ST_PH1;
                    start   = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_HOLD: state_d = cs_n ? ST_REC : ST_HOLD;
            ST_REC:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            acc_wr   <= 1'b0;
            acc_addr <= '0;
        end else begin
            state <= state_d;
            if (start) begin
                acc_addr <= addr;
                acc_wr   <= wr_low ? ~dir : dir;
            end
        end
    end

    assign commit = (state == ST_PH5) && acc_wr;
endmodule

// File: rtl/hrp_drive.sv
module hrp_drive
    import hrp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  hrp_state_e        state,
    input  logic              len_var,
    input  logic              cs_n,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy_out,
    output logic              rdy_oe
);
    logic in_late;

    // output decode
    always_comb begin
        rdy_oe  = 1'b0;
        rdy_out = 1'b1;
        in_late = 1'b0;
        unique case (state)
            ST_IDLE, ST_REC: begin
                rdy_oe  = len_var;
                rdy_out = 1'b1;
            end
            ST_PH1, ST_PH2, ST_PH3, ST_PH4: begin
                rdy_oe  = 1'b1;
                rdy_out = 1'b1;
            end
            ST_PH5: begin
                rdy_oe  = 1'b1;
                in_late = len_var ? !cs_n : 1'b1;
                rdy_out = !in_late;
            end
            ST_HOLD: begin
                rdy_oe  = 1'b1;
                in_late = len_var && !cs_n;
                rdy_out = !in_late;
            end
            default: begin
                rdy_oe  = len_var;
                rdy_out = 1'b1;
            end
        endcase
        data_oe  = in_late && !acc_wr;
        data_out = data_oe ? rd_data : '0;
    end
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hrp_port.sv
module hrp_port
    import hrp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              dir,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              rdy_out,
    output logic              rdy_oe
);
    hrp_state_e        state;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;
    logic              wr_commit;
    logic [DATA_W-1:0] rd_data;

    hrp_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_var  (acc_mode[1]),
        .wr_low   (acc_mode[0]),
        .cs_n     (cs_n),
        .dir      (dir),
        .addr     (addr),
        .state    (state),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr),
        .commit   (wr_commit)
    );

    hrp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_commit),
        .waddr (acc_addr),
        .wdata (data_in),
        .raddr (acc_addr),
        .rdata (rd_data)
    );

    hrp_drive #(.DATA_W(DATA_W)) u_drive (
        .state    (state),
        .len_var  (acc_mode[1]),
        .cs_n     (cs_n),
        .acc_wr   (acc_wr),
        .rd_data  (rd_data),
        .data_out (data_out),
        .data_oe  (data_oe),
        .rdy_out  (rdy_out),
        .rdy_oe   (rdy_oe)
    );
endmodule

// File: rtl/hrp_port_chk.sv
module hrp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] acc_mode,
    input logic       cs_n,
    input logic       data_oe,
    input logic       rdy_out,
    input logic       rdy_oe,
    input logic       commit
);
    assert_ready_single_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_mode[1] && rdy_oe && !rdy_out) |=> (!rdy_oe || rdy_out));

    assert_four_high_before_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_mode[1] && rdy_oe && !rdy_out) |-> ($past(rdy_oe, 4) && $past(rdy_out, 1)));

    assert_data_with_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (rdy_oe && !rdy_out));

    assert_ready_always_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mode[1] |-> rdy_oe);

    assert_cs_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode[1] && cs_n) |-> (rdy_out && !data_oe));

    assert_single_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
endmodule

bind hrp_port hrp_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_mode (acc_mode),
    .cs_n     (cs_n),
    .data_oe  (data_oe),
    .rdy_out  (rdy_out),
    .rdy_oe   (rdy_oe),
    .commit   (wr_commit)
);

// File: tb/hrp_port_test.sv
module hrp_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {mode[1:0], write, addr[5:0], data[7:0], hold[2:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {2'b00, 1'b1, 6'd0,  8'h11, 3'd0},
        {2'b00, 1'b0, 6'd0,  8'h11, 3'd0},
        {2'b01, 1'b1, 6'd63, 8'hA5, 3'd0},
        {2'b01, 1'b0, 6'd63, 8'hA5, 3'd0},
        {2'b10, 1'b1, 6'd17, 8'h3C, 3'd0},
        {2'b10, 1'b0, 6'd17, 8'h3C, 3'd3},
        {2'b11, 1'b1, 6'd42, 8'hC3, 3'd2},
        {2'b11, 1'b0, 6'd42, 8'hC3, 3'd0},
        {2'b11, 1'b0, 6'd0,  8'h11, 3'd0},
        {2'b00, 1'b0, 6'd17, 8'h3C, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_mode = 2'b00;
    logic [5:0] addr = '0;
    logic       cs_n = 1'b1;
    logic       dir = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       doe, rdy, rdy_oe;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    hrp_port uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_mode (acc_mode),
        .addr     (addr),
        .cs_n     (cs_n),
        .dir      (dir),
        .data_in  (din),
        .data_out (dout),
        .data_oe  (doe),
        .rdy_out  (rdy),
        .rdy_oe   (rdy_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic dir_level(input logic [1:0] m, input bit wr);
        logic wl;
        wl = m[0] ? 1'b0 : 1'b1;
        return wr ? wl : ~wl;
    endfunction

    task automatic access(input logic [1:0] m, input bit wr, input logic [5:0] a,
                          input logic [7:0] d, input int hold, input string rtag);
        @(negedge clk);
        acc_mode = m; cs_n = 1'b0; addr = a; dir = dir_level(m, wr); din = d;
        if (!m[1]) begin
            for (int k = 1; k <= 5; k++) begin
                @(negedge clk);
                if (k == 1) cs_n = 1'b1;
                #1;
                chk("R2", "rdy_oe fixed", int'(rdy_oe), 1);
                chk("R2", "rdy fixed", int'(rdy), (k != 5) ? 1 : 0);
                chk("R3", "data_oe fixed", int'(doe), (k == 5 && !wr) ? 1 : 0);
                if (k == 5 && !wr) chk(rtag, "read byte", int'(dout), int'(d));
            end
            @(negedge clk); #1;
            chk("R2", "rdy_oe idle", int'(rdy_oe), 0);
        end else begin
            for (int k = 1; k <= 5 + hold; k++) begin
                @(negedge clk); #1;
                chk("R6", "rdy_oe var", int'(rdy_oe), 1);
                chk("R6", "rdy var", int'(rdy), (k < 5) ? 1 : 0);
                chk("R6", "data_oe var", int'(doe), (k >= 5 && !wr) ? 1 : 0);
                if (k >= 5 && !wr) chk(rtag, "read byte", int'(dout), int'(d));
            end
            @(negedge clk);
            cs_n = 1'b1;
            #1;
            chk("R7", "rdy release", int'(rdy), 1);
            chk("R7", "data_oe release", int'(doe), 0);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk("R1", "rdy_oe after reset", int'(rdy_oe), 0);
        chk("R1", "data_oe after reset", int'(doe), 0);
        access(2'b00, 1'b0, 6'd5, 8'h00, 0, "R1");
        access(2'b00, 1'b0, 6'd63, 8'h00, 0, "R1");

        // table of accesses across all four mode combinations
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][19:18], VEC[i][17], VEC[i][16:11], VEC[i][10:3],
                   int'(VEC[i][2:0]), "R4 R11");
        end

        // R5: back-to-back fixed accesses
        @(negedge clk);
        acc_mode = 2'b00; cs_n = 1'b0; addr = 6'd20; dir = dir_level(2'b00, 1'b1); din = 8'h77;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1) cs_n = 1'b1;
            if (k == 5) begin cs_n = 1'b0; dir = dir_level(2'b00, 1'b0); end
            #1;
            chk("R5", "rdy first", int'(rdy), (k != 5) ? 1 : 0);
        end
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 1) cs_n = 1'b1;
            #1;
            chk("R5", "rdy_oe chained", int'(rdy_oe), 1);
            chk("R5", "rdy chained", int'(rdy), (k != 5) ? 1 : 0);
            if (k == 5) chk("R5", "chained read", int'(dout), 32'h77);
        end
        @(negedge clk); #1;
        chk("R5", "idle after chain", int'(rdy_oe), 0);

        // R8: chip select low in recovery clock is not sampled
        access(2'b10, 1'b1, 6'd30, 8'h81, 0, "R8");
        @(negedge clk);
        acc_mode = 2'b10; cs_n = 1'b0; addr = 6'd30; dir = dir_level(2'b10, 1'b0);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); #1;
            chk("R8", "rdy after recovery", int'(rdy), (k < 6) ? 1 : 0);
            if (k == 6) chk("R8", "read after recovery", int'(dout), 32'h81);
        end
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);

        // R9: abandoned write leaves the register alone
        access(2'b11, 1'b1, 6'd9, 8'h44, 0, "R9");
        @(negedge clk);
        acc_mode = 2'b11; cs_n = 1'b0; addr = 6'd9; dir = dir_level(2'b11, 1'b1); din = 8'h99;
        for (int k = 1; k <= 3; k++) @(negedge clk);
        cs_n = 1'b1;
        #1;
        chk("R9", "rdy on abort", int'(rdy), 1);
        @(negedge clk);
        access(2'b11, 1'b0, 6'd9, 8'h44, 0, "R9");

        // R10: write taken once at the fifth clock
        @(negedge clk);
        acc_mode = 2'b10; cs_n = 1'b0; addr = 6'd50; dir = dir_level(2'b10, 1'b1); din = 8'h2D;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 6) din = 8'hD2;
        end
        cs_n = 1'b1;
        @(negedge clk);
        access(2'b10, 1'b0, 6'd50, 8'h2D, 0, "R10");

        // R1: reset again clears the registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(2'b00, 1'b0, 6'd17, 8'h00, 0, "R1");
        access(2'b01, 1'b0, 6'd50, 8'h00, 0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule